// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Polarity

This block is a configurable two-level logic array. It has `N_IN` inputs, `N_TERM` product terms and `N_OUT` outputs. Each input reaches the AND plane both as itself and as its complement. A connection mask for each product term picks which of these literals the term multiplies together. A second mask for each output picks which product terms that output ORs. A polarity bit then XORs each OR result, so the output gives either the function or its inverse. The path from `in_vec` to `out_vec` has no registers.

The connection masks and polarity bits form one serial configuration chain. The chain shifts in on `cfg_clk` while `cfg_en` is high. During loading the outputs are held at 0. The `plane_mode` input can freeze either plane. In fixed-OR mode a hardwired term-to-output pattern replaces the OR masks. In fixed-AND mode a full minterm decoder replaces the AND masks, so the array behaves like a small lookup memory.

Top module: `sop_array`

## Requirements
- R1: Literal 2i of a product term is `in_vec[i]` and literal 2i+1 is `~in_vec[i]`. A mask bit of 1 (intact) includes that literal in the term's AND. A term with no intact literals is 1.
- R2: A product term with every literal intact contains both x and ~x, so it is always 0.
- R3: In user mode each output ORs the product terms whose OR mask bit is 1. With no term selected, the OR result is 0 before polarity.
- R4: Polarity bit 0 passes the OR result unchanged to the output. Polarity bit 1 inverts it.
- R5: The chain is CFG_W = N_IN*2*N_TERM + N_TERM*N_OUT + N_OUT bits. One bit shifts in per rising `cfg_clk` edge while `cfg_en` is 1. Stream position k (0 = first bit sent) is:
  - for k < AND_W: literal bit l of term p, where k = p*2*N_IN + l;
  - for AND_W <= k < AND_W+OR_W: OR bit for term p to output j, where k - AND_W = p*N_OUT + j;
  - for the last N_OUT positions: the polarity bit of output j, at k = AND_W + OR_W + j.
- R6: `out_vec` is all zeros whenever `cfg_en` is 1.
- R7: Asynchronous active-low reset clears every configuration bit. The outputs then read 0 in user mode. While `cfg_en` is 0, clock edges leave the configuration unchanged.
- R8: `plane_mode` = 2'b01 is fixed-OR mode. Term p feeds output (p mod N_OUT) only, and the OR mask bits are ignored. The AND masks and polarity bits still apply.
- R9: `plane_mode` = 2'b10 is fixed-AND mode. Term p is 1 exactly when `in_vec` equals p (terms at p >= 2^N_IN are 0), and the AND mask bits are ignored. `plane_mode` = 2'b11 behaves as 2'b00 (user mode).
- R10: Outputs follow `in_vec` and `plane_mode` combinationally, with no clock edge needed.
- R11: With 3 inputs, f1 = Σm(1,2,3,7) on `out_vec[0]` and f2 = Σm(0,1,2,6) on `out_vec[1]` can be built either with true outputs or with complemented covers and polarity 1. The minterm index is `in_vec`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the chain |
| cfg_en | input | 1 | Shift enable; forces outputs to 0 |
| cfg_din | input | 1 | Serial configuration bit, first bit = stream position 0 |
| plane_mode | input | 2 | 00/11 user, 01 fixed-OR, 10 fixed-AND |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Logic outputs after polarity |

## Verification
A new configuration takes effect at the rising edge that shifts its last bit, so the bench drops `cfg_en` on the next falling edge and only then applies data. Every data result is due in the same cycle as its stimulus, because the array is purely combinational. The bench therefore changes `in_vec` or `plane_mode` between clock edges and samples one time unit later, with no edge in between. The zero-during-load check is taken partway through a shift, after a falling edge, while the previous configuration would otherwise drive ones.

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 2
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_din,
  input  logic [1:0]        plane_mode,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_OUT-1:0]  out_vec
);
  localparam int LIT   = 2 * N_IN;
  localparam int AND_W = N_TERM * LIT;
  localparam int OR_W  = N_TERM * N_OUT;
  localparam int CFG_W = AND_W + OR_W + N_OUT;
  localparam int N_MIN = 1 << N_IN;

  logic [CFG_W-1:0]  cfg;
  logic [LIT-1:0]    lit;
  logic [N_TERM-1:0] term;
  logic              fix_or, fix_and;

  assign fix_or  = (plane_mode == 2'b01);
  assign fix_and = (plane_mode == 2'b10);

  always_ff @(posedge cfg_clk or negedge rst_n)
    if (!rst_n)      cfg <= '0;
    else if (cfg_en) cfg <= {cfg[CFG_W-2:0], cfg_din};

  // R7
  cfg_hold_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg));

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = in_vec[i];
    assign lit[2*i+1] = ~in_vec[i];
  end

  for (genvar p = 0; p < N_TERM; p++) begin : g_term
    logic [LIT-1:0] mask;
    logic           dec;
    for (genvar l = 0; l < LIT; l++) begin : g_m
      assign mask[l] = cfg[CFG_W-1-(p*LIT+l)];
    end
    if (p < N_MIN) begin : g_dec
      assign dec = (in_vec == N_IN'(p));
    end else begin : g_nodec
      assign dec = 1'b0;
    end
    assign term[p] = fix_and ? dec : &(lit | ~mask);

    // R2
    full_mask_zero_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      (!fix_and && (&mask)) |-> !term[p]);
  end

  // R9
  decoder_onehot_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    fix_and |-> $onehot0(term));

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [N_TERM-1:0] usr, sel;
    logic              pol;
    for (genvar p = 0; p < N_TERM; p++) begin : g_s
      assign usr[p] = cfg[CFG_W-1-(AND_W+p*N_OUT+j)];
      assign sel[p] = fix_or ? ((p % N_OUT) == j) : usr[p];
    end
    assign pol        = cfg[N_OUT-1-j];
    assign out_vec[j] = cfg_en ? 1'b0 : ((|(term & sel)) ^ pol);

    // R3
    empty_or_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      (!cfg_en && !fix_or && (usr == '0)) |-> (out_vec[j] == pol));
  end

  // R6
  load_quiet_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_en |-> (out_vec == '0));
endmodule

// File: tb/sop_array_bench.sv
module sop_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 3, N_TERM = 8, N_OUT = 2;
  localparam int LIT = 2 * N_IN;
  localparam int AND_W = N_TERM * LIT;
  localparam int OR_W = N_TERM * N_OUT;
  localparam int CFG_W = AND_W + OR_W + N_OUT;

  // expected {f2,f1} for in_vec = 0..7
  localparam logic [1:0] FTAB [8] = '{2'b10, 2'b11, 2'b11, 2'b01,
                                      2'b00, 2'b00, 2'b10, 2'b01};

  logic cfg_clk = 0, rst_n = 0, cfg_en = 0, cfg_din = 0;
  logic [1:0] plane_mode = 2'b00;
  logic [N_IN-1:0] in_vec = '0;
  logic [N_OUT-1:0] out_vec;
  logic [CFG_W-1:0] img;
  int checks = 0, failures = 0;

  sop_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_sop_array (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .plane_mode(plane_mode), .in_vec(in_vec), .out_vec(out_vec));

  always #(CLK_PERIOD/2) cfg_clk = ~cfg_clk;

  task automatic check(input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: out_vec=%b expected=%b (in=%0d mode=%b)", tag, act, exp, in_vec, plane_mode);
    end
  endtask

  task automatic set_and(input int p, input int l); img[CFG_W-1-(p*LIT+l)] = 1'b1; endtask
  task automatic set_or(input int p, input int j);  img[CFG_W-1-(AND_W+p*N_OUT+j)] = 1'b1; endtask
  task automatic set_pol(input int j);              img[N_OUT-1-j] = 1'b1; endtask

  task automatic load(input bit mid_check, input logic [N_IN-1:0] probe);
    @(negedge cfg_clk);
    cfg_en = 1;
    for (int k = 0; k < CFG_W; k++) begin
      if (k != 0) @(negedge cfg_clk);
      cfg_din = img[CFG_W-1-k];
      if (mid_check && k == CFG_W/2) begin
        in_vec = probe;
        #1 check(out_vec, '0, "R6 outputs held low while loading");
      end
    end
    @(negedge cfg_clk);
    cfg_en = 0;
    cfg_din = 0;
  endtask

  task automatic apply(input logic [N_IN-1:0] v, input logic [1:0] m);
    in_vec = v;
    plane_mode = m;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    apply(3'd0, 2'b00); check(out_vec, 2'b00, "R7 reset state in=0");
    apply(3'd7, 2'b00); check(out_vec, 2'b00, "R7 reset state in=7");
    rst_n = 1;

    // form A: true outputs (R11, R1, R3, R5)
    img = '0;
    set_and(0,5); set_and(0,3); set_and(0,0);
    set_and(1,5); set_and(1,2);
    set_and(2,2); set_and(2,0);
    set_and(3,5); set_and(3,1);
    set_and(4,2); set_and(4,1);
    set_or(0,0); set_or(1,0); set_or(2,0);
    set_or(0,1); set_or(3,1); set_or(4,1);
    load(0, '0);
    for (int v = 0; v < 8; v++) begin
      apply(3'(v), 2'b00);
      check(out_vec, FTAB[v], "R11 R10 true-form f1/f2");
    end

    // R7: clocks with cfg_en low keep the configuration
    cfg_din = 1;
    repeat (5) @(posedge cfg_clk);
    @(negedge cfg_clk);
    apply(3'd3, 2'b00); check(out_vec, FTAB[3], "R7 config held without cfg_en");
    cfg_din = 0;

    // form B: complemented covers, polarity 1 (R4, R11), mid-load zero (R6)
    img = '0;
    set_and(0,4); set_and(0,3);
    set_and(1,2); set_and(1,0);
    set_and(2,4); set_and(2,1);
    set_and(3,3); set_and(3,1);
    set_or(0,0); set_or(2,0); set_or(3,0);
    set_or(0,1); set_or(1,1);
    set_pol(0); set_pol(1);
    load(1, 3'd1);
    for (int v = 0; v < 8; v++) begin
      apply(3'(v), 2'b00);
      check(out_vec, FTAB[v], "R11 R4 complement-form f1/f2");
    end

    // R2 + R3 + R4: all-intact term, empty OR with polarity 1
    img = '0;
    for (int l = 0; l < LIT; l++) set_and(0, l);
    set_or(0,0);
    set_pol(1);
    load(0, '0);
    apply(3'd0, 2'b00); check(out_vec, 2'b10, "R2 R3 R4 all-intact term, empty OR inverted");
    apply(3'd7, 2'b00); check(out_vec, 2'b10, "R2 R3 R4 all-intact term, empty OR inverted");

    // R1: empty term is 1; single complemented/true literals
    img = '0;
    set_or(0,0);
    set_and(1,5); set_and(1,0);
    set_or(1,1);
    for (int p = 2; p < N_TERM; p++) for (int l = 0; l < LIT; l++) set_and(p, l);
    load(0, '0);
    for (int v = 0; v < 8; v++) begin
      apply(3'(v), 2'b00);
      check(out_vec, {~v[2] & v[0], 1'b1}, "R1 literal selection");
    end

    // R8: fixed-OR mode ignores OR bits
    img = '0;
    set_and(0,0); set_and(1,2);
    for (int p = 2; p < N_TERM; p++) for (int l = 0; l < LIT; l++) set_and(p, l);
    load(0, '0);
    for (int v = 0; v < 4; v++) begin
      apply(3'(v), 2'b00); check(out_vec, 2'b00, "R3 user mode, no OR bits");
      apply(3'(v), 2'b01); check(out_vec, 2'(v), "R8 fixed-OR routing");
      apply(3'(v), 2'b11); check(out_vec, 2'b00, "R9 mode 11 acts as user mode");
    end

    // R9: fixed-AND mode ignores AND bits
    img = '0;
    for (int p = 0; p < N_TERM; p++) for (int l = 0; l < LIT; l++) set_and(p, l);
    set_or(1,0); set_or(2,0); set_or(3,0); set_or(7,0);
    set_or(0,1); set_or(1,1); set_or(2,1); set_or(6,1);
    load(0, '0);
    for (int v = 0; v < 8; v++) begin
      apply(3'(v), 2'b10); check(out_vec, FTAB[v], "R9 fixed-AND decoder");
      apply(3'(v), 2'b00); check(out_vec, 2'b00, "R2 user mode all-intact terms");
    end
    apply(3'd5, 2'b01); check(out_vec, 2'b00, "R8 fixed-OR keeps AND masks");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule